// File: doc/BRIEF.md
# Command Completion Status Merger

This block closes out a tape-controller command. A command can run as up to two sub-operations, for example a space followed by a read. Each sub-operation leaves a 32-bit result word. The upper half carries extended status flags. The lower half carries subsystem status flags and a 3-bit termination class in bits 3:1. On a start strobe the block merges the two words. From the merge it forms the extended status word, the message header code and the final subsystem status value.

The message packet goes to memory through a request/acknowledge handshake that also carries an error input. The memory bus itself is outside this block. The message is skipped when a buffer address is still needed. A write that fails forces the class to "retry, tape moved" and raises the nonexistent-memory flag. Completion is marked by a one-cycle done strobe. When the command enabled interrupts, a one-cycle interrupt request goes out in the same cycle.

Top module: `cmd_done_merge`

## Requirements
- R1: The termination class in `ssr_o[3:1]` after completion is the larger of the two class fields `res_a_i[3:1]` and `res_b_i[3:1]`. Class codes run 0 ok, 1 attention, 2 status alert, 3 function reject, 4 retry with tape moved, 5 retry, 6 position lost, 7 fatal.
- R2: `msg_xst_o` is the OR of the two upper halves. Subsystem flag bits 12:8 and bit 0 of `ssr_o` are the OR of the two lower halves.
- R3: `msg_hdr_o` has bit 15 set, and its low byte is a code chosen by the merged class:
  - classes 0 and 2 give 8'h10 (end);
  - class 1 gives 8'h13 (attention);
  - class 3 gives 8'h11 (fail);
  - classes 4 to 7 give 8'h12 (error).
- R4: At completion `ssr_o[15]` is set exactly when the final class is nonzero and `ssr_o[7]` (ready) is set. While a message write is pending, `ssr_o[7]` is clear. After reset `ssr_o` reads only the ready bit plus the offline bit.
- R5: `ssr_o[14:13]` and `ssr_o[5:4]` always read zero. `ssr_o[6]` follows `offline_i` in the same cycle.
- R6: When `nba_i` or bit 10 of either lower half is set at start, no message request is made. Completion follows one cycle after the start edge, and `ssr_o[10]` is set.
- R7: When the acknowledge comes with `msg_err_i` high, the final status has bit 11 set and class 4, with bit 15 set.
- R8: `irq_o` pulses for one cycle together with `done_o`, only when `ie_i` was high at the accepted start.
- R9: A start strobe that arrives while a message write is pending is ignored. Header, extended word and final status keep the values of the command in flight.
- R10: `msg_req_o` rises one cycle after an accepted start and stays high until the cycle with `msg_ack_i`. The final status and `done_o` appear in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command end strobe; results valid |
| res_a_i | input | 32 | First sub-operation result word |
| res_b_i | input | 32 | Second sub-operation result word |
| ie_i | input | 1 | Command interrupt enable |
| nba_i | input | 1 | Message buffer address not yet set |
| offline_i | input | 1 | No medium loaded |
| msg_req_o | output | 1 | Message packet write request |
| msg_hdr_o | output | 16 | Message header word |
| msg_xst_o | output | 16 | Merged extended status word |
| msg_ack_i | input | 1 | Message write accepted |
| msg_err_i | input | 1 | Message write hit nonexistent memory |
| ssr_o | output | 16 | Subsystem status value |
| done_o | output | 1 | Completion strobe |
| irq_o | output | 1 | Interrupt request strobe |

## Verification
A new start strobe can land in the same cycle as the acknowledge that finishes the pending command. It can also land in the completion cycle of a command that skipped its message. The bench provokes both with random starts in every cycle, including starts during pending writes. In the first case the start must be dropped. In the second it must be taken as a fresh command. The behavioural model decides which, and every output is compared against it on every clock.

// File: rtl/cmd_done_pkg.sv
package cmd_done_pkg;
  localparam int HW      = 16;
  localparam int CLS_LSB = 1;
  localparam int CLS_W   = 3;

  localparam int SC_BIT  = 15;
  localparam int NXM_BIT = 11;
  localparam int NBA_BIT = 10;
  localparam int RDY_BIT = 7;
  localparam int OFL_BIT = 6;

  localparam logic [HW-1:0] PASS_MASK = 16'h1F01;

  typedef enum logic [CLS_W-1:0] {
    CLS_OK    = 3'd0,
    CLS_ATTN  = 3'd1,
    CLS_ALERT = 3'd2,
    CLS_REJ   = 3'd3,
    CLS_RETMV = 3'd4,
    CLS_RETRY = 3'd5,
    CLS_LOST  = 3'd6,
    CLS_FATAL = 3'd7
  } cls_e;

  typedef enum logic [7:0] {
    MC_END  = 8'h10,
    MC_FAIL = 8'h11,
    MC_ERR  = 8'h12,
    MC_ATTN = 8'h13
  } msg_code_e;

  localparam logic [HW-1:0] HDR_ACK = 16'h8000;
endpackage

// File: rtl/cmd_done_merge_core.sv
module cmd_done_merge_core
  import cmd_done_pkg::*;
#(
  parameter int W = HW
) (
  input  logic [2*W-1:0] res_a_i,
  input  logic [2*W-1:0] res_b_i,
  output logic [CLS_W-1:0] cls_o,
  output logic [W-1:0]     flags_o,
  output logic [W-1:0]     xst_o
);
  logic [2*W-1:0]   both;
  logic [CLS_W-1:0] cls_a, cls_b;

  always_comb begin
    both    = res_a_i | res_b_i;
    cls_a   = res_a_i[CLS_LSB +: CLS_W];
    cls_b   = res_b_i[CLS_LSB +: CLS_W];
    cls_o   = (cls_a > cls_b) ? cls_a : cls_b;
    flags_o = both[W-1:0] & PASS_MASK;
    xst_o   = both[2*W-1:W];
  end
endmodule

// File: rtl/cmd_done_hdr_map.sv
module cmd_done_hdr_map
  import cmd_done_pkg::*;
#(
  parameter int W = HW
) (
  input  logic [CLS_W-1:0] cls_i,
  output logic [W-1:0]     hdr_o
);
  msg_code_e code;

  always_comb begin
    unique case (cls_e'(cls_i))
      CLS_OK, CLS_ALERT: code = MC_END;
      CLS_ATTN:          code = MC_ATTN;
      CLS_REJ:           code = MC_FAIL;
      default:           code = MC_ERR;
    endcase
    hdr_o = HDR_ACK | W'(code);
  end
endmodule

// File: rtl/cmd_done_ctrl.sv
module cmd_done_ctrl
  import cmd_done_pkg::*;
#(
  parameter int W = HW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CLS_W-1:0] cls_i,
  input  logic [W-1:0]     flags_i,
  input  logic [W-1:0]     xst_i,
  input  logic [W-1:0]     hdr_i,
  input  logic             ie_i,
  input  logic             nba_i,
  input  logic             offline_i,
  input  logic             ack_i,
  input  logic             err_i,
  output logic             req_o,
  output logic [W-1:0]     hdr_o,
  output logic [W-1:0]     xst_o,
  output logic [W-1:0]     ssr_o,
  output logic             done_o,
  output logic             irq_o
);
  localparam logic [W-1:0] RDY_ONLY = W'(1) << RDY_BIT;

  logic             busy_q, done_q, irq_q, ie_q;
  logic [CLS_W-1:0] cls_q;
  logic [W-1:0]     flg_q, ssr_q, hdr_q, xst_q;
  logic             accept, skip_msg;
  logic [W-1:0]     flg_in;
  logic [CLS_W-1:0] fin_cls;
  logic [W-1:0]     fin_flg;

  function automatic logic [W-1:0] pack_ssr(input logic [CLS_W-1:0] c,
                                            input logic [W-1:0] f);
    logic [W-1:0] s;
    s = (f & PASS_MASK) | RDY_ONLY;
    s[CLS_LSB +: CLS_W] = c;
    s[SC_BIT] = (c != '0);
    return s;
  endfunction

  always_comb begin
    accept   = start_i & ~busy_q;
    skip_msg = nba_i | flags_i[NBA_BIT];
    flg_in   = flags_i;
    flg_in[NBA_BIT] = skip_msg;
    // failed message write overrides the merged class
    fin_cls  = err_i ? CLS_W'(CLS_RETMV) : cls_q;
    fin_flg  = flg_q;
    if (err_i) fin_flg[NXM_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      ie_q   <= 1'b0;
      cls_q  <= '0;
      flg_q  <= '0;
      ssr_q  <= RDY_ONLY;
      hdr_q  <= '0;
      xst_q  <= '0;
    end else begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      if (accept) begin
        hdr_q <= hdr_i;
        xst_q <= xst_i;
        ie_q  <= ie_i;
        cls_q <= cls_i;
        flg_q <= flg_in;
        if (skip_msg) begin
          ssr_q  <= pack_ssr(cls_i, flg_in);
          done_q <= 1'b1;
          irq_q  <= ie_i;
        end else begin
          busy_q <= 1'b1;
          ssr_q  <= '0;
        end
      end else if (busy_q && ack_i) begin
        busy_q <= 1'b0;
        ssr_q  <= pack_ssr(fin_cls, fin_flg);
        done_q <= 1'b1;
        irq_q  <= ie_q;
      end
    end
  end

  always_comb begin
    ssr_o = ssr_q;
    ssr_o[OFL_BIT] = offline_i;
  end

  assign req_o  = busy_q;
  assign hdr_o  = hdr_q;
  assign xst_o  = xst_q;
  assign done_o = done_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/cmd_done_merge.sv
module cmd_done_merge
  import cmd_done_pkg::*;
#(
  parameter int HALF_W = HW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2*HALF_W-1:0] res_a_i,
  input  logic [2*HALF_W-1:0] res_b_i,
  input  logic              ie_i,
  input  logic              nba_i,
  input  logic              offline_i,
  output logic              msg_req_o,
  output logic [HALF_W-1:0] msg_hdr_o,
  output logic [HALF_W-1:0] msg_xst_o,
  input  logic              msg_ack_i,
  input  logic              msg_err_i,
  output logic [HALF_W-1:0] ssr_o,
  output logic              done_o,
  output logic              irq_o
);
  logic [CLS_W-1:0]  m_cls;
  logic [HALF_W-1:0] m_flags, m_xst, m_hdr;

  cmd_done_merge_core #(.W(HALF_W)) u_core (
    .res_a_i (res_a_i),
    .res_b_i (res_b_i),
    .cls_o   (m_cls),
    .flags_o (m_flags),
    .xst_o   (m_xst)
  );

  cmd_done_hdr_map #(.W(HALF_W)) u_map (
    .cls_i (m_cls),
    .hdr_o (m_hdr)
  );

  cmd_done_ctrl #(.W(HALF_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cls_i     (m_cls),
    .flags_i   (m_flags),
    .xst_i     (m_xst),
    .hdr_i     (m_hdr),
    .ie_i      (ie_i),
    .nba_i     (nba_i),
    .offline_i (offline_i),
    .ack_i     (msg_ack_i),
    .err_i     (msg_err_i),
    .req_o     (msg_req_o),
    .hdr_o     (msg_hdr_o),
    .xst_o     (msg_xst_o),
    .ssr_o     (ssr_o),
    .done_o    (done_o),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/cmd_done_merge_chk.sv
module cmd_done_merge_chk #(
  parameter int HALF_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [2*HALF_W-1:0] res_a_i,
  input logic [2*HALF_W-1:0] res_b_i,
  input logic              ie_i,
  input logic              nba_i,
  input logic              offline_i,
  input logic              msg_req_o,
  input logic [HALF_W-1:0] msg_hdr_o,
  input logic [HALF_W-1:0] msg_xst_o,
  input logic              msg_ack_i,
  input logic              msg_err_i,
  input logic [HALF_W-1:0] ssr_o,
  input logic              done_o,
  input logic              irq_o
);
  a_r6_no_msg_on_nba: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !msg_req_o && (nba_i || res_a_i[10] || res_b_i[10]))
      |=> (!msg_req_o && done_o && ssr_o[10]));

  a_r10_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_req_o && !msg_ack_i) |=> msg_req_o);

  a_r10_ack_completes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_req_o && msg_ack_i) |=> (done_o && !msg_req_o));

  a_r7_err_forces_retry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_req_o && msg_ack_i && msg_err_i) |=> (ssr_o[11] && ssr_o[3:1] == 3'd4 && ssr_o[15]));

  a_r8_irq_only_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_o);

  a_r4_not_ready_while_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_req_o |-> !ssr_o[7]);

  a_r9_hdr_stable_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_req_o && !msg_ack_i) |=> $stable(msg_hdr_o) && $stable(msg_xst_o));
endmodule

bind cmd_done_merge cmd_done_merge_chk #(.HALF_W(HALF_W)) u_chk (.*);

// File: tb/cmd_done_merge_test.sv
module cmd_done_merge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, ie = 1'b0, nba = 1'b0, offline = 1'b0;
  logic        ack = 1'b0, err = 1'b0;
  logic [31:0] ra = '0, rb = '0;
  logic        req, done, irq;
  logic [15:0] hdr, xst, ssr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cmd_done_merge uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .res_a_i(ra), .res_b_i(rb),
    .ie_i(ie), .nba_i(nba), .offline_i(offline), .msg_req_o(req),
    .msg_hdr_o(hdr), .msg_xst_o(xst), .msg_ack_i(ack), .msg_err_i(err),
    .ssr_o(ssr), .done_o(done), .irq_o(irq));

  // reference model
  bit       m_busy, m_done, m_irq, m_ie;
  int       m_cls;
  bit [15:0] m_flg, m_ssr, m_hdr, m_xst;

  function automatic bit [15:0] code_of(int c);
    if (c == 0 || c == 2) return 16'h8010;
    if (c == 1) return 16'h8013;
    if (c == 3) return 16'h8011;
    return 16'h8012;
  endfunction

  function automatic bit [15:0] fin(int c, bit [15:0] f);
    bit [15:0] s;
    s = (f & 16'h1F01) | 16'h0080 | 16'(c << 1);
    if (c != 0) s = s | 16'h8000;
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_irq = 0; m_ie = 0; m_cls = 0;
      m_flg = 0; m_ssr = 16'h0080; m_hdr = 0; m_xst = 0;
    end else begin
      m_done = 0; m_irq = 0;
      if (start && !m_busy) begin
        int ca, cb;
        ca = int'(ra[3:1]); cb = int'(rb[3:1]);
        m_cls = (ca > cb) ? ca : cb;
        m_flg = (ra[15:0] | rb[15:0]) & 16'h1F01;
        m_xst = ra[31:16] | rb[31:16];
        m_hdr = code_of(m_cls);
        m_ie  = ie;
        if (nba || m_flg[10]) begin
          m_flg[10] = 1;
          m_ssr = fin(m_cls, m_flg);
          m_done = 1; m_irq = ie;
        end else begin
          m_busy = 1; m_ssr = 0;
        end
      end else if (m_busy && ack) begin
        m_busy = 0;
        if (err) begin m_cls = 4; m_flg[11] = 1; end
        m_ssr = fin(m_cls, m_flg);
        m_done = 1; m_irq = m_ie;
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit [15:0] e_ssr;
    e_ssr = m_ssr | (offline ? 16'h0040 : 16'h0);
    chk(ssr[3:1] == e_ssr[3:1], "R1 R7 class", ssr[3:1], e_ssr[3:1]);
    chk((ssr & 16'h1F01) == (e_ssr & 16'h1F01), "R2 R6 R7 flags", ssr, e_ssr);
    chk(xst == m_xst, "R2 R9 xst", xst, m_xst);
    chk(hdr == m_hdr, "R3 R9 hdr", hdr, m_hdr);
    chk(ssr[15] == e_ssr[15] && ssr[7] == e_ssr[7], "R4 sc/ready", ssr, e_ssr);
    chk(ssr[14:13] == 0 && ssr[5:4] == 0 && ssr[6] == offline, "R5 fixed bits", ssr, e_ssr);
    chk(req == m_busy, "R6 R9 R10 req", req, m_busy);
    chk(done == m_done, "R10 done", done, m_done);
    chk(irq == m_irq, "R8 irq", irq, m_irq);
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    start = 0; ack = 0; err = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(); // R4 reset state
    rst_n = 1;
    step();
    // R1 R3: class 7 vs 2, message written ok
    ra = 32'hA000_0104; rb = 32'h0500_000E; ie = 1; start = 1;
    step(); idle();
    step(); step();
    ack = 1; step(); idle(); step();
    // R7: failed write forces class 4
    ra = 32'h0001_0002; rb = 32'h0; ie = 0; start = 1;
    step(); idle(); ack = 1; err = 1; step(); idle(); step();
    // R6: nba skips message
    ra = 32'h0000_0006; rb = 32'h0000_0002; nba = 1; ie = 1; start = 1;
    step(); idle(); nba = 0; step();
    // R6: bit 10 in result also skips
    ra = 32'h0000_0400; rb = 32'h0; start = 1; step(); idle(); step();
    // R9: start while pending is ignored
    ra = 32'h0000_0002; rb = 32'h0; start = 1; step();
    ra = 32'hFFFF_000E; start = 1; step(); step();
    idle(); offline = 1; step(); ack = 1; start = 1; step(); idle(); step();
    offline = 0;
    // random mix, starts coincide with acks and done cycles
    for (int i = 0; i < 3000; i++) begin
      start   = ($urandom_range(0, 2) == 0);
      ack     = ($urandom_range(0, 3) == 0);
      err     = ($urandom_range(0, 3) == 0);
      nba     = ($urandom_range(0, 5) == 0);
      ie      = $urandom_range(0, 1) == 1;
      offline = ($urandom_range(0, 7) == 0);
      ra = $urandom; rb = $urandom;
      if ($urandom_range(0, 3) != 0) begin ra[10] = 0; rb[10] = 0; end
      step();
    end
    idle();
    step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule